// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one pulse-width modulated output from a single 32-bit control word. The control word holds an enable flag, a flag that forces full duty, an 8-bit pulse width and a 13-bit divider. Every clock cycle counts as one input tick. The divider splits these ticks into slower steps, and a 256-step period counter advances on each step. The output is high while the period count is below the programmed width.

Software writes the control word through a strobe-and-data port and can read it back at any time. A write does not wait for the running period to end. It reloads both counters, so the new setting starts a fresh period on the next cycle. Clearing the enable flag pulls the output low at once.

Top module: `pwm_gen`

## Requirements
- R1: The divider field sits in bits [12:0]. With a field value D, one period lasts 256*(D+1) clock cycles, so D=0 gives the fastest period of 256 cycles.
- R2: The width field sits in bits [23:16]. With width W and bit 24 clear, the output is high for the first W*(D+1) cycles of each period and low for the rest.
- R3: When bit 24 is set and the block is enabled, the output stays high for the whole period, whatever the width field holds.
- R4: A width of 0 with bit 24 clear keeps the output low for the whole time the block is enabled.
- R5: Bit 31 is the enable flag. A write that clears it makes the output 0 from the cycle after the write, and the output stays 0 while the flag is clear.
- R6: Every write restarts the divider and the period counter from zero, so the new setting begins a fresh period in the cycle after the strobe.
- R7: The read-back port returns the stored control word. Bits 30:25 and 15:13 always read as zero, so a write of all ones reads back as 0x81FF1FFF.
- R8: Synchronous reset clears the control word and both counters, and it drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Each cycle is one input tick. |
| rst | input | 1 | Synchronous reset, active high. |
| wr_en | input | 1 | Write strobe for the control word. |
| wr_data | input | 32 | Control word to store. |
| rd_data | output | 32 | Stored control word, with reserved bits forced to zero. |
| pwm_out | output | 1 | Modulated output. |

## Verification
Two things can happen in the same cycle: a register write, and a divider step or period wrap. With a divider value of 0, every cycle is a step, so any write in the middle of a period lands on a step. The bench writes a narrow width while a wide pulse is in progress. It then checks that the output shows exactly the new width, measured from the cycle after the strobe. The bench also checks the output phase across the first cycles after the write, to confirm that the restart won over the step.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int REG_W    = 32;
    localparam int DIV_W    = 13;
    localparam int WID_W    = 8;
    localparam int DIV_LSB  = 0;
    localparam int WID_LSB  = 16;
    localparam int FULL_BIT = 24;
    localparam int EN_BIT   = 31;

    typedef struct packed {
        logic             en;
        logic             full;
        logic [WID_W-1:0] width;
        logic [DIV_W-1:0] div;
    } pwm_cfg_t;

    function automatic pwm_cfg_t cfg_decode(input logic [REG_W-1:0] w);
        pwm_cfg_t c;
        c.en    = w[EN_BIT];
        c.full  = w[FULL_BIT];
        c.width = w[WID_LSB +: WID_W];
        c.div   = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_encode(input pwm_cfg_t c);
        logic [REG_W-1:0] w;
        w                     = '0;
        w[EN_BIT]             = c.en;
        w[FULL_BIT]           = c.full;
        w[WID_LSB +: WID_W]   = c.width;
        w[DIV_LSB +: DIV_W]   = c.div;
        return w;
    endfunction
endpackage

// File: rtl/pwm_cfg_reg.sv
module pwm_cfg_reg
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output pwm_cfg_t         cfg,
    output logic             restart
);
    pwm_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (wr_en)
            cfg_q <= cfg_decode(wr_data);
    end

    assign cfg     = cfg_q;
    assign restart = wr_en;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int DW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic [DW-1:0] pre,
    output logic          tick
);
    logic [DW-1:0] pre_q;

    assign tick = run && (pre_q == div);

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            pre_q <= '0;
        else if (tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

    assign pre = pre_q;
endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic          full,
    input  logic [CW-1:0] width,
    output logic [CW-1:0] cnt,
    output logic          out
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
    assign out = run && (full || (cnt_q < width));
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             pwm_out
);
    pwm_cfg_t         cfg;
    logic             restart;
    logic             step;
    logic [DIV_W-1:0] pre_q;
    logic [WID_W-1:0] cnt_q;

    pwm_cfg_reg u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cfg(cfg), .restart(restart)
    );

    pwm_prescaler #(.DW(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .clear(restart), .run(cfg.en),
        .div(cfg.div), .pre(pre_q), .tick(step)
    );

    pwm_period #(.CW(WID_W)) u_per (
        .clk(clk), .rst(rst), .clear(restart), .run(cfg.en), .tick(step),
        .full(cfg.full), .width(cfg.width), .cnt(cnt_q), .out(pwm_out)
    );

    assign rd_data = cfg_encode(cfg);
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
    import pwm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] rd_data,
    input logic             pwm_out,
    input logic [DIV_W-1:0] pre,
    input logic [WID_W-1:0] cnt
);
    localparam logic [REG_W-1:0] RSV_MASK = ~cfg_encode(pwm_cfg_t'('1));

    // R5
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[EN_BIT] |-> !pwm_out);

    // R3
    full_high_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[EN_BIT] && rd_data[FULL_BIT]) |-> pwm_out);

    // R4
    zero_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[FULL_BIT] && rd_data[WID_LSB +: WID_W] == '0) |-> !pwm_out);

    // R7
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & RSV_MASK) == '0);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt == '0 && pre == '0));

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && cnt != $past(cnt)) |-> cnt == $past(cnt) + 1'b1);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0 && cnt == '0 && pre == '0 && !pwm_out));
endmodule

bind pwm_gen pwm_gen_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_data(rd_data),
    .pwm_out(pwm_out), .pre(pre_q), .cnt(cnt_q)
);

// File: tb/tb_pwm_gen.sv
module tb_pwm_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int total = 0;
    int bad   = 0;

    pwm_gen dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
                 .rd_data(rd_data), .pwm_out(pwm_out));

    always #5 clk = ~clk;

    // control word, expected high cycles, cycles per period
    localparam int NV = 7;
    localparam logic [31:0] V_DATA [NV] = '{
        32'h8040_0000, 32'h8000_0000, 32'h80FF_0000, 32'h8110_0000,
        32'h800A_0002, 32'h0080_0000, 32'h80C8_0001 };
    localparam int V_HIGH [NV] = '{64, 0, 255, 256, 30, 0, 400};
    localparam int V_LEN  [NV] = '{256, 256, 256, 256, 768, 256, 512};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int len, output int hi);
        hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
    endtask

    task automatic phase(input int n, input logic [15:0] pat, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(pwm_out == pat[i], tag, int'(pwm_out), int'(pat[i]));
        end
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(rd_data == 32'h0, "R8 reset rd_data", int'(rd_data), 0);
        chk(pwm_out == 1'b0, "R8 reset out", int'(pwm_out), 0);

        // table: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            wr(V_DATA[v]);
            count_high(V_LEN[v], hi);
            chk(hi == V_HIGH[v], $sformatf("R1/R2/R3/R4/R5 vector %0d", v), hi, V_HIGH[v]);
        end

        // R7 reserved bits read zero
        wr(32'hFFFF_FFFF);
        @(negedge clk);
        chk(rd_data == 32'h81FF_1FFF, "R7 readback mask", int'(rd_data), int'(32'h81FF_1FFF));
        wr(32'h8123_4567);
        @(negedge clk);
        chk(rd_data == 32'h8123_0567, "R7 readback value", int'(rd_data), int'(32'h8123_0567));

        // R6 phase after write: width 3, div 0 -> high,high,high,low
        wr(32'h8003_0000);
        phase(4, 16'b0111, "R6 phase after write");

        // R1 div 3, width 1 -> 4 cycles high then low
        wr(32'h8001_0003);
        phase(5, 16'b01111, "R1 divider ratio");

        // R6 write mid-period coinciding with a step
        wr(32'h80C8_0000);
        repeat (100) @(negedge clk);
        chk(pwm_out == 1'b1, "R6 before update", int'(pwm_out), 1);
        wr(32'h8005_0000);
        count_high(256, hi);
        chk(hi == 5, "R6 immediate update width", hi, 5);

        // R5 disable cuts period short
        wr(32'h80C8_0000);
        repeat (10) @(negedge clk);
        chk(pwm_out == 1'b1, "R5 running", int'(pwm_out), 1);
        wr(32'h00C8_0000);
        count_high(20, hi);
        chk(hi == 0, "R5 disabled output", hi, 0);

        // R3 full duty ignores width 0
        wr(32'h8100_0000);
        count_high(300, hi);
        chk(hi == 300, "R3 full duty width ignored", hi, 300);

        // R8 reset mid-run
        wr(32'h80C8_0000);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(pwm_out == 1'b0, "R8 reset mid-run out", int'(pwm_out), 0);
        chk(rd_data == 32'h0, "R8 reset mid-run rd_data", int'(rd_data), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule